// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Controller

This block sits next to a CPU core. It picks one interrupt to service among a set of maskable request lines, a non-maskable top-level interrupt and a software trap. Each maskable line has a programmable 2-bit priority. A 2-bit current level, the interrupt mask bits of the condition register, blocks every line whose priority is not above it. Arbitration takes place only when the core reports that an instruction has completed. Among the eligible requests the highest priority wins, and a tie goes to the line with the lower vector address.

When a request is accepted, the block asks the core to save its context. It then loads the current level with the priority of the winner and drives a program-counter load with the vector address of the winner. The level that was current at entry goes onto a small internal stack. A return strobe pops that level back, so service routines can nest up to the stack depth. A push onto a full stack, or a pop from an empty one, sets a sticky error flag.

The core can also set the current level directly while the block is idle, for example to enable interrupts. The priorities are written and read back through a small address/data port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the current level is 3, every priority field reads 3, `save_o`, `pc_load_o` and `err_o` are 0, and no request is accepted until the level is lowered or a non-maskable source is asserted.
- R2: A write with `cfg_we_i` high sets the priority of line `cfg_addr_i` to `cfg_wdata_i`. `cfg_rdata_o` returns that priority combinationally. An address at or above NIRQ reads as 0 and its write is ignored.
- R3: A maskable line is eligible only when it is asserted and its priority is strictly greater than the current level (0 is lowest, 3 highest). The highest eligible priority wins, and among equal priorities the lowest line index wins.
- R4: The block accepts a request at a clock edge where it is idle, `eoi_i` is high and something is eligible. `save_o` is then high for exactly the next cycle. In the cycle after that, `pc_load_o` is high for one cycle and the current level already equals the level of the winner.
- R5: While `pc_load_o` is high, `vec_addr_o` is 0x008004 for the trap, 0x008008 for the top-level interrupt, and 0x00800C + 4*i for maskable line i.
- R6: The trap and the top-level interrupt are accepted at any current level, including 3, and set the current level to 3. Both rank above all maskable lines, and the trap ranks above the top-level interrupt.
- R7: An `iret_i` pulse while idle restores the current level to the value most recently pushed at entry (last in, first out).
- R8: An entry with DEPTH levels already saved sets `err_o` and still loads the new level. An `iret_i` with nothing saved sets `err_o` and leaves the level unchanged. `err_o` stays high until reset.
- R9: When `iret_i` and an `eoi_i` with an eligible request arrive in the same idle cycle, the return is performed and no request is accepted in that cycle.
- R10: `lvl_we_i` sets the current level to `lvl_wdata_i` only in an idle cycle with no return and no acceptance. It is ignored during an entry sequence.
- R11: Without `eoi_i`, and during an entry sequence, no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eoi_i | input | 1 | End-of-instruction strobe |
| irq_i | input | NIRQ | Maskable request lines |
| tli_i | input | 1 | Non-maskable top-level interrupt |
| trap_i | input | 1 | Software trap request |
| iret_i | input | 1 | Return-from-interrupt strobe |
| lvl_we_i | input | 1 | Direct write of the current level |
| lvl_wdata_i | input | 2 | Level value for a direct write |
| cfg_we_i | input | 1 | Priority write enable |
| cfg_addr_i | input | AW | Priority line index |
| cfg_wdata_i | input | 2 | Priority write data |
| cfg_rdata_o | output | 2 | Priority read data |
| save_o | output | 1 | Context-save request |
| pc_load_o | output | 1 | Program-counter load strobe |
| vec_addr_o | output | VW | Vector address to fetch |
| ccr_lvl_o | output | 2 | Current level (mask bits I1, I0) |
| err_o | output | 1 | Sticky save-stack overflow/underflow flag |

## Verification
A return and a new acceptance can both be requested in one idle cycle. Both change the current level and the save stack. The bench takes one nested entry, then raises `iret_i` and `eoi_i` together while a line with priority 2 is asserted. The cycle that follows must show no `save_o` and the restored level. A separate `eoi_i` after that must then accept the pending line against the restored level, with the correct vector.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NIRQ = 29,
  parameter int DEPTH = 4,
  parameter int AW = 5,
  parameter int VW = 24,
  parameter logic [VW-1:0] BASE = 24'h008000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eoi_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            tli_i,
  input  logic            trap_i,
  input  logic            iret_i,
  input  logic            lvl_we_i,
  input  logic [1:0]      lvl_wdata_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [1:0]      cfg_wdata_i,
  output logic [1:0]      cfg_rdata_o,
  output logic            save_o,
  output logic            pc_load_o,
  output logic [VW-1:0]   vec_addr_o,
  output logic [1:0]      ccr_lvl_o,
  output logic            err_o
);
  localparam int SW  = $clog2(NIRQ + 2);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_JUMP} st_t;

  st_t            st;
  logic [1:0]     prio [NIRQ];
  logic [1:0]     stk [DEPTH];
  logic [SPW-1:0] sp;
  logic [1:0]     ccr, win_lvl, hit_lvl;
  logic [SW-1:0]  win_slot, hit_slot;
  logic           hit, accept, stk_full, stk_empty;

  always_comb begin
    hit = 1'b0;
    hit_lvl = 2'd3;
    hit_slot = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (irq_i[i] && prio[i] > ccr && (!hit || prio[i] >= hit_lvl)) begin
        hit = 1'b1;
        hit_lvl = prio[i];
        hit_slot = SW'(i + 2);
      end
    end
    if (tli_i) begin
      hit = 1'b1;
      hit_lvl = 2'd3;
      hit_slot = SW'(1);
    end
    if (trap_i) begin
      hit = 1'b1;
      hit_lvl = 2'd3;
      hit_slot = '0;
    end
  end

  assign accept    = (st == S_IDLE) && eoi_i && !iret_i && hit;
  assign stk_full  = (sp == SPW'(DEPTH));
  assign stk_empty = (sp == '0);

  assign cfg_rdata_o = (int'(cfg_addr_i) < NIRQ) ? prio[cfg_addr_i] : 2'd0;
  assign save_o      = (st == S_SAVE);
  assign pc_load_o   = (st == S_JUMP);
  assign vec_addr_o  = pc_load_o ? BASE + VW'((int'(win_slot) + 1) * 4) : '0;
  assign ccr_lvl_o   = ccr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIRQ; i++) prio[i] <= 2'd3;
    end else if (cfg_we_i && int'(cfg_addr_i) < NIRQ) begin
      prio[cfg_addr_i] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ccr      <= 2'd3;
      sp       <= '0;
      err_o    <= 1'b0;
      win_lvl  <= 2'd3;
      win_slot <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= 2'd0;
    end else begin
      case (st)
        S_IDLE: begin
          if (iret_i) begin
            if (stk_empty) begin
              err_o <= 1'b1;
            end else begin
              ccr <= stk[IW'(sp - 1'b1)];
              sp  <= sp - 1'b1;
            end
          end else if (accept) begin
            win_lvl  <= hit_lvl;
            win_slot <= hit_slot;
            st       <= S_SAVE;
          end else if (lvl_we_i) begin
            ccr <= lvl_wdata_i;
          end
        end
        S_SAVE: begin
          if (stk_full) begin
            err_o <= 1'b1;
          end else begin
            stk[IW'(sp)] <= ccr;
            sp <= sp + 1'b1;
          end
          ccr <= win_lvl;
          st  <= S_JUMP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int NIRQ = 29,
  parameter int VW = 24,
  parameter logic [VW-1:0] BASE = 24'h008000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eoi_i,
  input logic          save_o,
  input logic          pc_load_o,
  input logic [VW-1:0] vec_addr_o,
  input logic [1:0]    ccr_lvl_o,
  input logic          err_o
);
  AST_SAVE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n) save_o |=> (pc_load_o && !save_o)); // R4
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pc_load_o |=> !pc_load_o); // R4
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (vec_addr_o >= BASE + VW'(4) && vec_addr_o <= BASE + VW'(4 * (NIRQ + 2)) && vec_addr_o[1:0] == 2'b00)); // R5
  AST_NMI_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && vec_addr_o < BASE + VW'(12)) |-> ccr_lvl_o == 2'd3); // R6
  AST_MASKABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && vec_addr_o >= BASE + VW'(12)) |-> ccr_lvl_o > $past(ccr_lvl_o)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o); // R8
  AST_ACCEPT_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n) $rose(save_o) |-> $past(eoi_i)); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NIRQ(NIRQ), .VW(VW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi_i(eoi_i), .save_o(save_o), .pc_load_o(pc_load_o),
  .vec_addr_o(vec_addr_o), .ccr_lvl_o(ccr_lvl_o), .err_o(err_o)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NIRQ = 29;
  localparam int AW = 5;
  localparam int VW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi, tli, trap, iret, lvl_we, cfg_we;
  logic [NIRQ-1:0] irq;
  logic [1:0] lvl_wdata, cfg_wdata, cfg_rdata, ccr;
  logic [AW-1:0] cfg_addr;
  logic save, pc_load, err;
  logic [VW-1:0] vec;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .eoi_i(eoi), .irq_i(irq), .tli_i(tli), .trap_i(trap),
    .iret_i(iret), .lvl_we_i(lvl_we), .lvl_wdata_i(lvl_wdata), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .save_o(save), .pc_load_o(pc_load), .vec_addr_o(vec), .ccr_lvl_o(ccr), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {eoi, tli, trap, iret, lvl_we, cfg_we} = '0;
    irq = '0; lvl_wdata = '0; cfg_wdata = '0; cfg_addr = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic set_lvl(input logic [1:0] v);
    lvl_we = 1'b1; lvl_wdata = v;
    tick();
    lvl_we = 1'b0;
  endtask

  task automatic wr_prio(input int idx, input logic [1:0] v);
    cfg_we = 1'b1; cfg_addr = AW'(idx); cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic take(input string tag, input logic [23:0] exp_vec, input logic [1:0] exp_lvl);
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
    chk({tag, " save"}, 32'(save), 32'd1);
    tick();
    chk({tag, " pc_load"}, 32'(pc_load), 32'd1);
    chk({tag, " vector"}, 32'(vec), 32'(exp_vec));
    chk({tag, " level"}, 32'(ccr), 32'(exp_lvl));
    tick();
    chk({tag, " pc_load end"}, 32'(pc_load), 32'd0);
  endtask

  task automatic do_iret(input string tag, input logic [1:0] exp_lvl);
    iret = 1'b1;
    tick();
    iret = 1'b0;
    chk({tag, " iret level"}, 32'(ccr), 32'(exp_lvl));
  endtask

  task automatic t_reset();
    chk("R1 level", 32'(ccr), 32'd3);
    chk("R1 save", 32'(save), 32'd0);
    chk("R1 pc_load", 32'(pc_load), 32'd0);
    chk("R1 err", 32'(err), 32'd0);
    cfg_addr = 5'd0; #1;
    chk("R1 prio0", 32'(cfg_rdata), 32'd3);
    cfg_addr = 5'd28; #1;
    chk("R1 prio28", 32'(cfg_rdata), 32'd3);
    irq = '1; eoi = 1'b1;
    tick();
    eoi = 1'b0; irq = '0;
    chk("R1 masked at 3", 32'(save), 32'd0);
  endtask

  task automatic t_cfg();
    wr_prio(5, 2'd1);
    cfg_addr = 5'd5; #1;
    chk("R2 readback", 32'(cfg_rdata), 32'd1);
    wr_prio(31, 2'd1);
    cfg_addr = 5'd31; #1;
    chk("R2 out of range", 32'(cfg_rdata), 32'd0);
  endtask

  task automatic t_mask();
    set_lvl(2'd1);
    chk("R10 level write", 32'(ccr), 32'd1);
    irq[5] = 1'b1; eoi = 1'b1;
    tick();
    eoi = 1'b0;
    chk("R3 equal level masked", 32'(save), 32'd0);
    set_lvl(2'd0);
    take("R3 unmasked", 24'h008020, 2'd1);
    irq = '0;
    do_iret("R7", 2'd0);
  endtask

  task automatic t_arb();
    wr_prio(3, 2'd2); wr_prio(7, 2'd2); wr_prio(10, 2'd1);
    irq[3] = 1'b1; irq[7] = 1'b1; irq[10] = 1'b1;
    take("R3 tie lowest index", 24'h008018, 2'd2);
    do_iret("R7 after tie", 2'd0);
    wr_prio(10, 2'd3);
    take("R5 highest level", 24'h008034, 2'd3);
    irq = '0;
    do_iret("R7 after high", 2'd0);
  endtask

  task automatic t_nmi();
    set_lvl(2'd3);
    trap = 1'b1; tli = 1'b1;
    take("R6 trap over tli", 24'h008004, 2'd3);
    trap = 1'b0;
    do_iret("R6 trap return", 2'd3);
    take("R6 tli at level 3", 24'h008008, 2'd3);
    tli = 1'b0;
    do_iret("R6 tli return", 2'd3);
    set_lvl(2'd0);
    irq[10] = 1'b1; trap = 1'b1;
    take("R6 trap over maskable", 24'h008004, 2'd3);
    irq = '0; trap = 1'b0;
    do_iret("R6 return", 2'd0);
  endtask

  task automatic t_busy();
    wr_prio(6, 2'd2);
    irq[6] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R11 no eoi", 32'(save), 32'd0);
    end
    eoi = 1'b1;
    tick();
    lvl_we = 1'b1; lvl_wdata = 2'd0;
    tick();
    eoi = 1'b0; lvl_we = 1'b0;
    chk("R10 write ignored when busy", 32'(ccr), 32'd2);
    chk("R5 line 6", 32'(vec), 32'h008024);
    tick();
    chk("R11 eoi ignored when busy", 32'(save), 32'd0);
    irq = '0;
    do_iret("R7 busy return", 2'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    do_iret("R8 underflow keeps level", 2'd3);
    chk("R8 underflow err", 32'(err), 32'd1);
  endtask

  task automatic t_nest();
    do_reset();
    wr_prio(1, 2'd1); wr_prio(2, 2'd2); wr_prio(4, 2'd3);
    set_lvl(2'd0);
    irq[1] = 1'b1; take("R7 nest1", 24'h008010, 2'd1); irq = '0;
    irq[2] = 1'b1; take("R7 nest2", 24'h008014, 2'd2); irq = '0;
    irq[4] = 1'b1; take("R7 nest3", 24'h00801C, 2'd3); irq = '0;
    tli = 1'b1; take("R7 nest4", 24'h008008, 2'd3); tli = 1'b0;
    chk("R8 no err at depth", 32'(err), 32'd0);
    trap = 1'b1; take("R8 overflow entry", 24'h008004, 2'd3); trap = 1'b0;
    chk("R8 overflow err", 32'(err), 32'd1);
    do_iret("R7 pop4", 2'd3);
    do_iret("R7 pop3", 2'd2);
    do_iret("R7 pop2", 2'd1);
    do_iret("R7 pop1", 2'd0);
    chk("R8 err sticky", 32'(err), 32'd1);
  endtask

  task automatic t_collide();
    do_reset();
    wr_prio(1, 2'd1); wr_prio(2, 2'd2);
    set_lvl(2'd0);
    irq[1] = 1'b1; take("R9 setup", 24'h008010, 2'd1); irq = '0;
    irq[2] = 1'b1; iret = 1'b1; eoi = 1'b1;
    tick();
    iret = 1'b0; eoi = 1'b0;
    chk("R9 no accept with iret", 32'(save), 32'd0);
    chk("R9 level restored", 32'(ccr), 32'd0);
    take("R9 deferred accept", 24'h008014, 2'd2);
    irq = '0;
    do_iret("R9 final", 2'd0);
    chk("R9 no err", 32'(err), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_cfg();
    t_mask();
    t_arb();
    t_nmi();
    t_busy();
    t_underflow();
    t_nest();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule